// File: doc/BRIEF.md
# Bit-Serial SIMD Pixel Processor Array

This block is a small grid of identical one-bit processing elements, one per pixel of a binarised image. All elements execute the same instruction at the same time. Each instruction names an operation, two source bit addresses and one destination bit address. Every element reads its two source bits into operands A and B, passes them through a one-bit ALU to produce a result Z, and writes Z back to the destination. Wider arithmetic, such as multi-bit sums, differences and magnitude comparisons, is built by issuing one instruction per bit, least significant bit first, through a per-element carry flag.

Each element has a 32-entry bit address space. Entries 0 to 23 are general storage. The upper eight entries are wired to the outside: the element's own pixel bit, its output bit, the output bits of its four nearest neighbours, and constant zeros. A program therefore moves data between neighbours by writing to the output bit and reading a neighbour address on a later instruction. The controller drives `step` high for one clock to issue each instruction.

Top module: `pe_grid`

## Requirements
- R1: While `rst_n` is low, all storage bits, the output bits and the carry flags are cleared, so `out_bits` reads zero in the cycle after reset is applied.
- R2: Read addresses 0–23 return storage bits. Address 24 returns the element's pixel, `pix[r*COLS+c]` for the element at row r and column c. Address 25 returns its own output bit. Addresses 30 and 31 return 0.
- R3: Address 26 reads the output bit of row r-1, 27 of row r+1, 28 of column c+1 and 29 of column c-1. Each of these is the value held before the current instruction. A neighbour position outside the grid reads 0.
- R4: An instruction executes on a rising edge where `step` is 1, and its effect is visible on `out_bits` after that edge. With `step` at 0, nothing changes.
- R5: A destination of 0–23 writes a storage bit and 25 writes the output bit. Destinations 24 and 26–31 change nothing.
- R6: Opcodes 0–9 compute Z as: A&B, A|B, A^B, ~(A&B), ~(A|B), ~(A^B), A, ~A, A&~B, A|~B. The carry flag does not change.
- R7: Opcode 10 (add) gives Z=A^B^C with new C=majority(A,B,C). Opcode 12 (first add bit) gives Z=A^B with new C=A&B.
- R8: Opcode 11 (subtract) gives Z=A^B^C with new C=(~A&(B|C))|(B&C), where C is a borrow. Opcode 13 (first subtract bit) gives Z=A^B with new C=~A&B.
- R9: Opcode 14 clears C and writes 0. Opcode 15 sets C and writes 1. Opcode 16 writes C and leaves C unchanged.
- R10: Opcode 17 (compare) sets C=(A&~B)|(~(A^B)&C) and writes the new C. Applied least significant bit first from C=0, it leaves C=1 exactly when A>B.
- R11: Opcodes 18–31 write nothing and leave the carry flag unchanged.
- R12: Every element executes the same instruction on its own data in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step | input | 1 | Execute the presented instruction on this edge |
| op | input | 5 | Operation code |
| ra | input | 5 | Bit address read into A |
| rb | input | 5 | Bit address read into B |
| wa | input | 5 | Bit address that receives Z |
| pix | input | ROWS*COLS | Binarised pixel bits, index r*COLS+c |
| out_bits | output | ROWS*COLS | Output bit of every element, same indexing |

## Verification
Each logical operation is applied to two stored pixel patterns whose per-element bit pairs cover all four combinations, so any swapped or inverted opcode shows up. Neighbour reads are tried with an all-ones output and with sparse, asymmetric patterns. These separate north from south and east from west, and expose any wrap-around at the grid edges. Serial add, subtract and compare sequences use known multi-bit values, so a wrong carry or borrow equation changes a visible result bit. Writes to input-only addresses and the no-operation opcodes are followed by a read-back through the output bit.

// File: rtl/pe_grid.sv
module pe_grid #(
  parameter int ROWS = 4,
  parameter int COLS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   step,
  input  logic [4:0]             op,
  input  logic [4:0]             ra,
  input  logic [4:0]             rb,
  input  logic [4:0]             wa,
  input  logic [ROWS*COLS-1:0]   pix,
  output logic [ROWS*COLS-1:0]   out_bits
);
  localparam int CELLS    = ROWS * COLS;
  localparam int RAM_BITS = 24;
  localparam logic [4:0] RAM_END = 5'(RAM_BITS);
  localparam logic [4:0] AD_PIX = 5'd24, AD_OUT = 5'd25, AD_N = 5'd26,
                         AD_S = 5'd27, AD_E = 5'd28, AD_W = 5'd29;

  localparam logic [4:0] OP_AND = 5'd0,  OP_OR   = 5'd1,  OP_XOR  = 5'd2,
                         OP_NAND = 5'd3, OP_NOR  = 5'd4,  OP_XNOR = 5'd5,
                         OP_A   = 5'd6,  OP_NA   = 5'd7,  OP_ANB  = 5'd8,
                         OP_AONB = 5'd9, OP_ADD  = 5'd10, OP_SUB  = 5'd11,
                         OP_ADD0 = 5'd12, OP_SUB0 = 5'd13, OP_CLC = 5'd14,
                         OP_SEC = 5'd15, OP_GETC = 5'd16, OP_CMP  = 5'd17;

  function automatic logic fetch(input logic [4:0] ad, input logic [RAM_BITS-1:0] m,
                                 input logic px, input logic ob, input logic nb,
                                 input logic sb, input logic eb, input logic wb);
    logic r;
    r = 1'b0;
    if (ad < RAM_END) r = m[ad];
    else begin
      case (ad)
        AD_PIX:  r = px;
        AD_OUT:  r = ob;
        AD_N:    r = nb;
        AD_S:    r = sb;
        AD_E:    r = eb;
        AD_W:    r = wb;
        default: r = 1'b0;
      endcase
    end
    return r;
  endfunction

  for (genvar i = 0; i < CELLS; i++) begin : g_pe
    localparam int R = i / COLS;
    localparam int C = i % COLS;

    logic [RAM_BITS-1:0] ram;
    logic cy, cy_nx, ob, nb, sb, eb, wb, a, b, z, live;

    if (R > 0)        begin : g_n  assign nb = out_bits[i-COLS]; end
    else              begin : g_n0 assign nb = 1'b0; end
    if (R < ROWS - 1) begin : g_s  assign sb = out_bits[i+COLS]; end
    else              begin : g_s0 assign sb = 1'b0; end
    if (C < COLS - 1) begin : g_e  assign eb = out_bits[i+1]; end
    else              begin : g_e0 assign eb = 1'b0; end
    if (C > 0)        begin : g_w  assign wb = out_bits[i-1]; end
    else              begin : g_w0 assign wb = 1'b0; end

    assign a = fetch(ra, ram, pix[i], ob, nb, sb, eb, wb);
    assign b = fetch(rb, ram, pix[i], ob, nb, sb, eb, wb);

    always_comb begin
      live  = 1'b1;
      z     = 1'b0;
      cy_nx = cy;
      case (op)
        OP_AND:  z = a & b;
        OP_OR:   z = a | b;
        OP_XOR:  z = a ^ b;
        OP_NAND: z = ~(a & b);
        OP_NOR:  z = ~(a | b);
        OP_XNOR: z = ~(a ^ b);
        OP_A:    z = a;
        OP_NA:   z = ~a;
        OP_ANB:  z = a & ~b;
        OP_AONB: z = a | ~b;
        OP_ADD: begin
          z     = a ^ b ^ cy;
          cy_nx = (a & b) | (a & cy) | (b & cy);
        end
        OP_SUB: begin
          z     = a ^ b ^ cy;
          cy_nx = (~a & (b | cy)) | (b & cy);
        end
        OP_ADD0: begin
          z     = a ^ b;
          cy_nx = a & b;
        end
        OP_SUB0: begin
          z     = a ^ b;
          cy_nx = ~a & b;
        end
        OP_CLC: begin
          z     = 1'b0;
          cy_nx = 1'b0;
        end
        OP_SEC: begin
          z     = 1'b1;
          cy_nx = 1'b1;
        end
        OP_GETC: z = cy;
        OP_CMP: begin
          cy_nx = (a & ~b) | (~(a ^ b) & cy);
          z     = cy_nx;
        end
        default: live = 1'b0;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ram <= '0;
        cy  <= 1'b0;
        ob  <= 1'b0;
      end else if (step && live) begin
        cy <= cy_nx;
        if (wa < RAM_END) ram[wa] <= z;
        else if (wa == AD_OUT) ob <= z;
      end
    end

    assign out_bits[i] = ob;
  end
endmodule

module pe_grid_chk #(
  parameter int CELLS = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step,
  input logic [4:0]       op,
  input logic [4:0]       ra,
  input logic [4:0]       rb,
  input logic [4:0]       wa,
  input logic [CELLS-1:0] pix,
  input logic [CELLS-1:0] out_bits
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (out_bits == '0));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(out_bits));

  // R5
  other_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && wa != 5'd25) |=> $stable(out_bits));

  // R11
  nop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && op >= 5'd18) |=> $stable(out_bits));

  // R2
  pixel_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && op == 5'd1 && ra == 5'd24 && rb == 5'd30 && wa == 5'd25)
      |=> (out_bits == $past(pix)));
endmodule

bind pe_grid pe_grid_chk #(.CELLS(ROWS*COLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .op(op), .ra(ra), .rb(rb),
  .wa(wa), .pix(pix), .out_bits(out_bits)
);

// File: tb/pe_grid_tb.sv
`timescale 1ns/1ps
module pe_grid_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, step = 1'b0;
  logic [4:0] op = '0, ra = '0, rb = '0, wa = '0;
  logic [15:0] pix = '0;
  logic [15:0] out_bits;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [23:0] mram [16];
  logic        mout [16];
  logic        mc   [16];

  always #4 clk = ~clk;

  pe_grid #(.ROWS(4), .COLS(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .step(step), .op(op), .ra(ra), .rb(rb),
    .wa(wa), .pix(pix), .out_bits(out_bits)
  );

  localparam int NV = 30;
  // op, ra, rb, wa, pix
  localparam logic [35:0] VEC [NV] = '{
    {5'd1,  5'd24, 5'd30, 5'd0,  16'hA5C3},
    {5'd1,  5'd24, 5'd30, 5'd1,  16'h0F0F},
    {5'd0,  5'd0,  5'd1,  5'd25, 16'h0000},
    {5'd2,  5'd0,  5'd1,  5'd25, 16'h0000},
    {5'd3,  5'd0,  5'd1,  5'd25, 16'h0000},
    {5'd4,  5'd0,  5'd1,  5'd25, 16'h0000},
    {5'd5,  5'd0,  5'd1,  5'd25, 16'h0000},
    {5'd6,  5'd0,  5'd1,  5'd25, 16'h0000},
    {5'd7,  5'd0,  5'd1,  5'd25, 16'h0000},
    {5'd8,  5'd0,  5'd1,  5'd25, 16'h0000},
    {5'd9,  5'd0,  5'd1,  5'd25, 16'h0000},
    {5'd1,  5'd24, 5'd30, 5'd25, 16'h1234},
    {5'd1,  5'd26, 5'd30, 5'd25, 16'h0000},
    {5'd1,  5'd24, 5'd30, 5'd25, 16'h8421},
    {5'd1,  5'd27, 5'd30, 5'd25, 16'h0000},
    {5'd1,  5'd24, 5'd30, 5'd25, 16'h6996},
    {5'd1,  5'd28, 5'd30, 5'd25, 16'h0000},
    {5'd1,  5'd24, 5'd30, 5'd25, 16'hF00F},
    {5'd1,  5'd29, 5'd31, 5'd25, 16'h0000},
    {5'd15, 5'd0,  5'd0,  5'd31, 16'h0000},
    {5'd10, 5'd0,  5'd1,  5'd25, 16'h0000},
    {5'd16, 5'd0,  5'd0,  5'd25, 16'h0000},
    {5'd11, 5'd0,  5'd1,  5'd25, 16'h0000},
    {5'd16, 5'd0,  5'd0,  5'd25, 16'h0000},
    {5'd13, 5'd0,  5'd1,  5'd25, 16'h0000},
    {5'd17, 5'd0,  5'd1,  5'd25, 16'h0000},
    {5'd14, 5'd0,  5'd0,  5'd25, 16'h0000},
    {5'd12, 5'd0,  5'd1,  5'd25, 16'h0000},
    {5'd20, 5'd24, 5'd30, 5'd25, 16'hFFFF},
    {5'd16, 5'd0,  5'd0,  5'd25, 16'h0000}
  };

  function automatic logic [15:0] model_out();
    logic [15:0] v;
    for (int p = 0; p < 16; p++) v[p] = mout[p];
    return v;
  endfunction

  function automatic logic mread(int p, logic [4:0] ad, logic [15:0] px);
    int r, c;
    r = p / 4;
    c = p % 4;
    if (ad < 5'd24) return mram[p][ad];
    case (ad)
      5'd24: return px[p];
      5'd25: return mout[p];
      5'd26: return (r > 0) ? mout[p-4] : 1'b0;
      5'd27: return (r < 3) ? mout[p+4] : 1'b0;
      5'd28: return (c < 3) ? mout[p+1] : 1'b0;
      5'd29: return (c > 0) ? mout[p-1] : 1'b0;
      default: return 1'b0;
    endcase
  endfunction

  task automatic model_reset();
    for (int p = 0; p < 16; p++) begin
      mram[p] = '0;
      mout[p] = 1'b0;
      mc[p]   = 1'b0;
    end
  endtask

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s out=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic run(input logic [4:0] o, input logic [4:0] a1, input logic [4:0] b1,
                     input logic [4:0] w, input logic [15:0] px, input string tag);
    logic [23:0] nram [16];
    logic nout [16];
    logic nc [16];
    @(negedge clk);
    op = o; ra = a1; rb = b1; wa = w; pix = px; step = 1'b1;
    for (int p = 0; p < 16; p++) begin
      logic av, bv, z, cn, ok;
      av = mread(p, a1, px);
      bv = mread(p, b1, px);
      cn = mc[p];
      z  = 1'b0;
      ok = 1'b1;
      case (o)
        5'd0:  z = av & bv;
        5'd1:  z = av | bv;
        5'd2:  z = av ^ bv;
        5'd3:  z = ~(av & bv);
        5'd4:  z = ~(av | bv);
        5'd5:  z = ~(av ^ bv);
        5'd6:  z = av;
        5'd7:  z = ~av;
        5'd8:  z = av & ~bv;
        5'd9:  z = av | ~bv;
        5'd10: begin z = av ^ bv ^ mc[p]; cn = (av & bv) | (mc[p] & (av | bv)); end
        5'd11: begin z = av ^ bv ^ mc[p]; cn = (!av && (bv || mc[p])) || (bv && mc[p]); end
        5'd12: begin z = av ^ bv; cn = av & bv; end
        5'd13: begin z = av ^ bv; cn = !av && bv; end
        5'd14: begin z = 1'b0; cn = 1'b0; end
        5'd15: begin z = 1'b1; cn = 1'b1; end
        5'd16: z = mc[p];
        5'd17: begin cn = (av > bv) ? 1'b1 : (av == bv) ? mc[p] : 1'b0; z = cn; end
        default: ok = 1'b0;
      endcase
      nram[p] = mram[p];
      nout[p] = mout[p];
      nc[p]   = mc[p];
      if (ok) begin
        nc[p] = cn;
        if (w < 5'd24) nram[p][w] = z;
        else if (w == 5'd25) nout[p] = z;
      end
    end
    for (int p = 0; p < 16; p++) begin
      mram[p] = nram[p];
      mout[p] = nout[p];
      mc[p]   = nc[p];
    end
    @(negedge clk);
    step = 1'b0;
    chk(tag, out_bits, model_out());
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog out=%h exp=done", out_bits);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 reset state", out_bits, 16'h0000);
    rst_n = 1'b1;

    // R12 table walk; also covers R6 R7 R8 R9 R10 R11 via the model
    for (int k = 0; k < NV; k++)
      run(VEC[k][35:31], VEC[k][30:26], VEC[k][25:21], VEC[k][20:16], VEC[k][15:0], "R12 table");

    // R3 edges with all-ones outputs
    run(5'd1, 5'd24, 5'd30, 5'd25, 16'hFFFF, "R2 pixel copy");
    chk("R2 pixel copy literal", out_bits, 16'hFFFF);
    run(5'd1, 5'd26, 5'd30, 5'd25, 16'h0000, "R3 north");
    chk("R3 north edge", out_bits, 16'hFFF0);
    run(5'd1, 5'd24, 5'd30, 5'd25, 16'hFFFF, "R3 reload");
    run(5'd1, 5'd28, 5'd30, 5'd25, 16'h0000, "R3 east");
    chk("R3 east edge", out_bits, 16'h7777);

    // R4 no strobe: instruction presented but not issued
    @(negedge clk);
    op = 5'd7; ra = 5'd25; wa = 5'd25; step = 1'b0;
    repeat (3) @(negedge clk);
    chk("R4 idle hold", out_bits, 16'h7777);

    // R5 writes to input-side addresses change nothing
    run(5'd1, 5'd30, 5'd30, 5'd26, 16'h0000, "R5 write north");
    chk("R5 write north literal", out_bits, 16'h7777);
    run(5'd1, 5'd30, 5'd30, 5'd24, 16'h5A5A, "R5 write pixel");
    run(5'd1, 5'd24, 5'd31, 5'd25, 16'h5A5A, "R5 pixel readback");
    chk("R5 pixel readback literal", out_bits, 16'h5A5A);

    // R7 serial add 3 + 1 = 4
    run(5'd1, 5'd24, 5'd30, 5'd0, 16'hFFFF, "R7 a0");
    run(5'd1, 5'd24, 5'd30, 5'd1, 16'hFFFF, "R7 a1");
    run(5'd1, 5'd30, 5'd30, 5'd2, 16'h0000, "R7 a2");
    run(5'd1, 5'd24, 5'd30, 5'd4, 16'hFFFF, "R7 b0");
    run(5'd1, 5'd30, 5'd30, 5'd5, 16'h0000, "R7 b1");
    run(5'd1, 5'd30, 5'd30, 5'd6, 16'h0000, "R7 b2");
    run(5'd12, 5'd0, 5'd4, 5'd8, 16'h0000, "R7 s0");
    run(5'd10, 5'd1, 5'd5, 5'd9, 16'h0000, "R7 s1");
    run(5'd10, 5'd2, 5'd6, 5'd10, 16'h0000, "R7 s2");
    run(5'd6, 5'd10, 5'd30, 5'd25, 16'h0000, "R7 sum bit2");
    chk("R7 sum bit2 literal", out_bits, 16'hFFFF);
    run(5'd6, 5'd8, 5'd30, 5'd25, 16'h0000, "R7 sum bit0");
    chk("R7 sum bit0 literal", out_bits, 16'h0000);

    // R8 serial subtract 2 - 1 = 1 (a in 0..1 rewritten to 2)
    run(5'd1, 5'd30, 5'd30, 5'd0, 16'h0000, "R8 a0");
    run(5'd13, 5'd0, 5'd4, 5'd8, 16'h0000, "R8 d0");
    run(5'd11, 5'd1, 5'd5, 5'd9, 16'h0000, "R8 d1");
    run(5'd6, 5'd8, 5'd30, 5'd25, 16'h0000, "R8 diff bit0");
    chk("R8 diff bit0 literal", out_bits, 16'hFFFF);
    run(5'd6, 5'd9, 5'd30, 5'd25, 16'h0000, "R8 diff bit1");
    chk("R8 diff bit1 literal", out_bits, 16'h0000);
    run(5'd16, 5'd0, 5'd0, 5'd25, 16'h0000, "R8 final borrow");
    chk("R8 final borrow literal", out_bits, 16'h0000);

    // R10 compare 2 > 1
    run(5'd14, 5'd0, 5'd0, 5'd31, 16'h0000, "R9 clear carry");
    run(5'd17, 5'd0, 5'd4, 5'd31, 16'h0000, "R10 cmp bit0");
    run(5'd17, 5'd1, 5'd5, 5'd25, 16'h0000, "R10 cmp bit1");
    chk("R10 greater literal", out_bits, 16'hFFFF);

    // R11 no-operation keeps output and carry
    run(5'd14, 5'd0, 5'd0, 5'd31, 16'h0000, "R9 clear");
    run(5'd31, 5'd24, 5'd30, 5'd25, 16'h0000, "R11 nop");
    chk("R11 nop literal", out_bits, 16'hFFFF);
    run(5'd16, 5'd0, 5'd0, 5'd25, 16'h0000, "R11 carry kept");
    chk("R11 carry kept literal", out_bits, 16'h0000);
    run(5'd15, 5'd0, 5'd0, 5'd25, 16'h0000, "R9 set carry");
    chk("R9 set carry literal", out_bits, 16'hFFFF);

    // R1 reset mid-run clears storage and carry
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    chk("R1 reset clears out", out_bits, 16'h0000);
    rst_n = 1'b1;
    run(5'd6, 5'd1, 5'd30, 5'd25, 16'h0000, "R1 storage cleared");
    chk("R1 storage cleared literal", out_bits, 16'h0000);
    run(5'd16, 5'd0, 5'd0, 5'd25, 16'h0000, "R1 carry cleared");
    chk("R1 carry cleared literal", out_bits, 16'h0000);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule